// File: doc/BRIEF.md
# Byte-Wide Flash Command Interface

This block models the control side of a byte-wide flash memory with active-low chip-enable, output-enable and write-enable strobes. It sorts the strobe levels into read, output-disable, standby and write cycles, and it drives the data bus or releases it. The bus is split into an output byte and an output-enable bit, so an enclosing pad ring can build the tri-state buffer. A small register file stands in for the memory cells. Analog conditions are reduced to three digital flags: programming supply high, supply above lockout, and high voltage present on the identifier address line.

The command register accepts bytes only while both supply flags are high. While either flag is low, the register is held in array-read mode and the block acts as a read-only memory. Program and erase each take two writes: a setup byte, then a data byte or a confirm byte. The manufacturer and device identifier codes can be read in two ways: through the high-voltage identifier flag, or through the identify command.

Top module: `flash_cmd_bus`

## Requirements
- R1: A read cycle is `ce_n`=0, `oe_n`=0, `we_n`=1, sampled at a rising clock edge. At that edge `dq_oe` is set to 1 and `dq_out` is loaded with the selected byte. Both are visible after the edge. In array-read mode the byte is the cell at `addr`.
- R2: After any edge where `ce_n` is high (standby), `oe_n` is high (output disable), or `we_n` is low, `dq_oe` is 0.
- R3: On a read cycle with `id_hv`=1 and `addr[ADDR_W-1:1]`=0, the block returns 0x89 when `addr[0]`=0 and 0xBD when `addr[0]`=1. This holds at any supply state. If any upper address bit is 1, the read returns the array byte instead.
- R4: A write is committed on the edge where `we_n` is sampled high after having been sampled low, while `ce_n`=0 and `oe_n`=1. If `ce_n` rises before `we_n` rises, nothing is committed.
- R5: While `vpp_hi`=0, the command register is forced to array-read mode, writes change neither the mode nor the array, and reads return array data.
- R6: While `vpp_hi`=1 and `vcc_ok`=0, command writes are ignored in the same way and the mode is held at array-read.
- R7: Writing 0x40 and then a data byte D to address A sets cell A to old AND D, so bits can only be cleared. A single write outside program setup never changes the array.
- R8: Writing 0x20 and then 0x20 sets every cell to 0xFF. Writing 0x20 and then any other byte leaves the array unchanged.
- R9: After command 0x90, reads return 0x89 when `addr[0]`=0 and 0xBD when `addr[0]`=1.
- R10: Command 0xA0 (verify) makes reads return array data. Commands 0x00, 0xFF and any undefined byte return the register to array-read mode.
- R11: Synchronous reset `rst` clears `dq_oe` and `dq_out`, sets every cell to 0xFF and selects array-read mode.
- R12: After a program or an erase completes, the register is in array-read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| id_hv | input | 1 | High voltage present on the identifier address line |
| vpp_hi | input | 1 | Programming supply is high |
| vcc_ok | input | 1 | Core supply is above the write lockout level |
| dq_in | input | DATA_W | Data bus, inbound |
| dq_out | output | DATA_W | Data bus, outbound (registered) |
| dq_oe | output | 1 | Data bus output enable (registered) |

## Verification
The bench builds the block with its defaults, ADDR_W=4 and DATA_W=8. That gives 16 cells, so after an erase every cell can be read back and checked for 0xFF. With 4 address bits, the identifier address qualifier covers three upper bits, so a read with `id_hv` set at a non-zero upper address can be checked to fall through to array data. The byte width keeps the program AND rule visible through two successive programs of one cell.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [2:0] {
    M_READ      = 3'd0,
    M_IDENT     = 3'd1,
    M_PGM_SETUP = 3'd2,
    M_ERS_SETUP = 3'd3,
    M_VERIFY    = 3'd4
  } fc_mode_e;

  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_PROGRAM = 8'h40;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_VERIFY  = 8'hA0;
  localparam logic [7:0] OP_RESET   = 8'hFF;
endpackage

// File: rtl/fc_strobe_decode.sv
module fc_strobe_decode (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_cycle,
  output logic wr_commit
);
  logic we_q;

  always_ff @(posedge clk) begin
    if (rst) we_q <= 1'b1;
    else     we_q <= we_n;
  end

  assign rd_cycle  = !ce_n && !oe_n && we_n;
  assign wr_commit = !ce_n && oe_n && we_n && !we_q;

  // a commit is a single edge event: the sampled enable is high afterwards
  p_commit_single_r4: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> !wr_commit);
endmodule

// File: rtl/fc_cmd_fsm.sv
module fc_cmd_fsm
  import fc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_en,
  input  logic              wr_commit,
  input  logic [DATA_W-1:0] wr_data,
  output fc_mode_e          mode,
  output logic              prog_en,
  output logic              erase_en
);
  fc_mode_e mode_q;
  logic     take;

  assign take     = cmd_en && wr_commit;
  assign prog_en  = take && (mode_q == M_PGM_SETUP);
  assign erase_en = take && (mode_q == M_ERS_SETUP) && (wr_data[7:0] == OP_ERASE);
  assign mode     = mode_q;

  always_ff @(posedge clk) begin
    if (rst || !cmd_en) begin
      mode_q <= M_READ;
    end else if (take) begin
      if (mode_q == M_PGM_SETUP || mode_q == M_ERS_SETUP) begin
        mode_q <= M_READ;
      end else begin
        case (wr_data[7:0])
          OP_IDENT:   mode_q <= M_IDENT;
          OP_PROGRAM: mode_q <= M_PGM_SETUP;
          OP_ERASE:   mode_q <= M_ERS_SETUP;
          OP_VERIFY:  mode_q <= M_VERIFY;
          default:    mode_q <= M_READ;
        endcase
      end
    end
  end

  // R5/R6: a locked supply leaves the register in array read
  p_locked_read_r5: assert property (@(posedge clk) disable iff (rst)
    !cmd_en |=> (mode == M_READ));
  // R12: a finished program or erase returns to array read
  p_done_read_r12: assert property (@(posedge clk) disable iff (rst)
    (prog_en || erase_en) |=> (mode == M_READ));
  p_ops_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(prog_en && erase_en));
endmodule

// File: rtl/fc_cell_array.sv
module fc_cell_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_en,
  input  logic              erase_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || erase_en) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '1;
    end else if (prog_en) begin
      cell_q[addr] <= cell_q[addr] & wdata;
    end
  end

  assign rdata = cell_q[addr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    // R7: programming can only clear bits
    p_prog_clear_only_r7: assert property (@(posedge clk) disable iff (rst)
      (prog_en && addr == ADDR_W'(g)) |=> ((cell_q[g] & ~$past(cell_q[g])) == '0));
    // R5: with no program or erase the cell holds
    p_cell_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !(prog_en || erase_en) |=> $stable(cell_q[g]));
    // R8: confirmed erase leaves all ones
    p_erase_ones_r8: assert property (@(posedge clk) disable iff (rst)
      erase_en |=> (cell_q[g] == '1));
  end
endmodule

// File: rtl/flash_cmd_bus.sv
module flash_cmd_bus
  import fc_pkg::*;
#(
  parameter int          ADDR_W = 4,
  parameter int          DATA_W = 8,
  parameter logic [7:0]  MFR_ID = 8'h89,
  parameter logic [7:0]  DEV_ID = 8'hBD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              id_hv,
  input  logic              vpp_hi,
  input  logic              vcc_ok,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  logic              rd_cycle, wr_commit, cmd_en, prog_en, erase_en, hv_hit;
  logic [DATA_W-1:0] cell_rd, id_byte, rd_sel;
  fc_mode_e          mode;

  assign cmd_en  = vpp_hi && vcc_ok;
  assign hv_hit  = id_hv && (addr[ADDR_W-1:1] == '0);
  assign id_byte = addr[0] ? DATA_W'(DEV_ID) : DATA_W'(MFR_ID);

  fc_strobe_decode u_strobe (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rd_cycle(rd_cycle), .wr_commit(wr_commit)
  );

  fc_cmd_fsm #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst(rst), .cmd_en(cmd_en), .wr_commit(wr_commit),
    .wr_data(dq_in), .mode(mode), .prog_en(prog_en), .erase_en(erase_en)
  );

  fc_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
    .clk(clk), .rst(rst), .prog_en(prog_en), .erase_en(erase_en),
    .addr(addr), .wdata(dq_in), .rdata(cell_rd)
  );

  always_comb begin
    if (hv_hit)                          rd_sel = id_byte;
    else if (cmd_en && mode == M_IDENT)  rd_sel = id_byte;
    else                                 rd_sel = cell_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      dq_oe  <= rd_cycle;
      if (rd_cycle) dq_out <= rd_sel;
    end
  end

  // R2: any non-read strobe pattern leaves the bus released
  p_bus_released_r2: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n || !we_n) |=> !dq_oe);
  // R3: high-voltage identifier read of the manufacturer byte
  p_hv_mfr_r3: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && we_n && id_hv && addr[ADDR_W-1:1] == '0 && !addr[0])
      |=> (dq_oe && dq_out == DATA_W'(MFR_ID)));
endmodule

// File: tb/test_flash_cmd_bus.sv
`timescale 1ns/1ps
module test_flash_cmd_bus;
  logic       clk = 1'b0;
  logic       rst, ce_n, oe_n, we_n, id_hv, vpp_hi, vcc_ok, dq_oe;
  logic [3:0] addr;
  logic [7:0] dq_in, dq_out, rb;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_bus i_flash_cmd_bus (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .id_hv(id_hv), .vpp_hi(vpp_hi), .vcc_ok(vcc_ok),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // {op(0 write,1 read,2 hv read), addr, data, expected, requirement}
  localparam logic [25:0] VEC [25] = '{
    {2'd1, 4'd3, 8'h00, 8'hFF, 4'd1},   // R1 erased cell
    {2'd0, 4'd5, 8'h40, 8'h00, 4'd7},   // R7 setup
    {2'd0, 4'd5, 8'h3C, 8'h00, 4'd7},
    {2'd1, 4'd5, 8'h00, 8'h3C, 4'd12},  // R12 back to array read
    {2'd0, 4'd5, 8'h40, 8'h00, 4'd7},
    {2'd0, 4'd5, 8'hF0, 8'h00, 4'd7},
    {2'd1, 4'd5, 8'h00, 8'h30, 4'd7},   // R7 AND rule
    {2'd0, 4'd2, 8'h5A, 8'h00, 4'd7},   // R7 stray write
    {2'd1, 4'd2, 8'h00, 8'hFF, 4'd7},
    {2'd0, 4'd0, 8'h90, 8'h00, 4'd9},   // R9 identify
    {2'd1, 4'd0, 8'h00, 8'h89, 4'd9},
    {2'd1, 4'd1, 8'h00, 8'hBD, 4'd9},
    {2'd0, 4'd0, 8'hFF, 8'h00, 4'd10},  // R10 reset command
    {2'd1, 4'd5, 8'h00, 8'h30, 4'd10},
    {2'd0, 4'd0, 8'hA0, 8'h00, 4'd10},  // R10 verify
    {2'd1, 4'd5, 8'h00, 8'h30, 4'd10},
    {2'd0, 4'd0, 8'h20, 8'h00, 4'd8},   // R8 unconfirmed erase
    {2'd0, 4'd0, 8'h00, 8'h00, 4'd8},
    {2'd1, 4'd5, 8'h00, 8'h30, 4'd8},
    {2'd2, 4'd0, 8'h00, 8'h89, 4'd3},   // R3 high-voltage codes
    {2'd2, 4'd1, 8'h00, 8'hBD, 4'd3},
    {2'd2, 4'd3, 8'h00, 8'hFF, 4'd3},   // R3 upper address set
    {2'd0, 4'd0, 8'h20, 8'h00, 4'd8},   // R8 confirmed erase
    {2'd0, 4'd0, 8'h20, 8'h00, 4'd8},
    {2'd1, 4'd5, 8'h00, 8'hFF, 4'd8}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; id_hv = 1'b0;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; dq_in = d; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); idle();
  endtask

  task automatic bus_read(input logic [3:0] a, input logic hv, output logic [7:0] d);
    @(negedge clk); addr = a; id_hv = hv; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    d = dq_oe ? dq_out : 8'hzz;
    idle();
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(); addr = '0; dq_in = '0; vpp_hi = 1'b1; vcc_ok = 1'b1; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 oe after reset", {7'd0, dq_oe}, 8'h00);
    check("R11 dout after reset", dq_out, 8'h00);

    for (int i = 0; i < 25; i++) begin
      if (VEC[i][25:24] == 2'd0) begin
        bus_write(VEC[i][23:20], VEC[i][19:12]);
      end else begin
        bus_read(VEC[i][23:20], VEC[i][25:24] == 2'd2, rb);
        check($sformatf("R%0d vector %0d", VEC[i][3:0], i), rb, VEC[i][11:4]);
      end
    end

    // R2: output disable and standby release the bus
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk); check("R2 output disable", {7'd0, dq_oe}, 8'h00);
    ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk); check("R2 standby", {7'd0, dq_oe}, 8'h00);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    @(negedge clk); check("R2 write enable low", {7'd0, dq_oe}, 8'h00);
    idle();

    // R4: chip enable released before write enable rises -> no commit
    bus_write(4'd9, 8'h40);
    @(negedge clk); addr = 4'd9; dq_in = 8'h00; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
    bus_read(4'd9, 1'b0, rb); check("R4 aborted write", rb, 8'hFF);
    bus_write(4'd9, 8'h0F);
    bus_read(4'd9, 1'b0, rb); check("R4 committed write", rb, 8'h0F);

    // R5: programming supply low
    vpp_hi = 1'b0;
    bus_write(4'd7, 8'h40); bus_write(4'd7, 8'h00);
    bus_read(4'd7, 1'b0, rb); check("R5 program ignored", rb, 8'hFF);
    vpp_hi = 1'b1; bus_write(4'd0, 8'h90); vpp_hi = 1'b0;
    bus_read(4'd1, 1'b0, rb); check("R5 forced array read", rb, 8'hFF);
    bus_read(4'd1, 1'b1, rb); check("R3 hv code with supply low", rb, 8'hBD);
    vpp_hi = 1'b1;
    bus_read(4'd1, 1'b0, rb); check("R5 mode stays array read", rb, 8'hFF);

    // R6: supply below lockout
    vcc_ok = 1'b0;
    bus_write(4'd7, 8'h40); bus_write(4'd7, 8'h00);
    bus_read(4'd7, 1'b0, rb); check("R6 program inhibited", rb, 8'hFF);
    bus_write(4'd0, 8'h90);
    bus_read(4'd0, 1'b0, rb); check("R6 identify inhibited", rb, 8'hFF);
    vcc_ok = 1'b1;

    // R8: full sweep after a confirmed erase
    bus_write(4'd0, 8'h20); bus_write(4'd0, 8'h20);
    for (int a = 0; a < 16; a++) begin
      bus_read(4'(a), 1'b0, rb); check($sformatf("R8 erased cell %0d", a), rb, 8'hFF);
    end

    // R11: reset restores cells and mode
    bus_write(4'd4, 8'h40); bus_write(4'd4, 8'h00);
    bus_read(4'd4, 1'b0, rb); check("R7 program to zero", rb, 8'h00);
    bus_write(4'd0, 8'h90);
    pulse_reset();
    bus_read(4'd4, 1'b0, rb); check("R11 cell restored", rb, 8'hFF);
    bus_read(4'd0, 1'b0, rb); check("R11 mode array read", rb, 8'hFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule